// File: doc/BRIEF.md
# Dual-Line Configurable Interrupt Controller

This block gathers 51 interrupt sources and reports them on two output lines: a normal interrupt line and a fast interrupt line. A fixed per-source trigger configuration sets how each source latches into a raw pending vector. A source can be level-sensitive and follow its pin. It can be edge-sensitive on one edge and stay latched until software clears it. Or it can be edge-sensitive on both edges. A per-source enable gates each raw bit, and a per-source route bit picks the line it drives.

Software reaches the block over a plain 32-bit register bus. The data read back is combinational and writes take a single cycle. Each 51-bit logical register appears as two words: a low word for sources 0 to 31 and a high word for sources 32 to 50. Address bit 2 picks between them. The active map occupies the 128-byte window that starts at 0x80. Below that window sits an inert legacy space. Enables and edge-pending bits each have a set port and a clear port, so no read-modify-write is needed. Only sources 47 to 50 have a polarity that software can change.

Top module: `dual_line_intc`

## Requirements
- R1: After reset, raw, enable and route read zero and both output lines are low. Trigger-mode (offset 0x40) reads 0xFFF8FFFF low and 0x1F07 high, both-edge (0x48) reads 0x00070000 and 0xF8, and polarity (0x50) reads 0xFFF8FFFF and 0x5F07.
- R2: A level source (mode bit 1) with polarity 1 has its raw bit equal to the pin as sampled at the previous clock edge. With polarity 0 the raw bit is the inverse of that pin value.
- R3: A single-edge source with polarity 1 sets its raw bit on a rising pin edge. The bit stays set after the pin returns low, until it is cleared through offset 0x58.
- R4: A single-edge source with polarity 0 sets raw on a falling pin edge and ignores a rising one.
- R5: A source with its both-edge bit set (sources 16 to 18 and 35 to 39) sets raw on either pin transition.
- R6: Writing 1s to edge-clear (0x58) clears those raw bits only for edge sources; level raw bits are unaffected. If an edge arrives in the same cycle as the clear, the edge wins and the raw bit is set.
- R7: Writing 1s to offset 0x20 sets those enable bits, and writing 1s to offset 0x28 clears them. Other bits are unchanged.
- R8: A write to route (0x18) replaces only the addressed word. Offset 0x00 reads raw&enable&~route and offset 0x08 reads raw&enable&route. Offset 0x60 reads raw&~mode.
- R9: irq_out is high one cycle after any raw&enable&~route bit is set. fiq_out is high one cycle after any raw&enable&route bit is set.
- R10: Polarity changes only through a high-word write, and then only in bits 15 to 18 (sources 47 to 50). A low-word polarity write has no effect.
- R11: Addresses below 0x80 read zero and ignore writes. Offsets 0x28, 0x38, 0x58, 0x30 and unmapped offsets such as 0x68 read zero. Writes to 0x00, 0x08, 0x10, 0x40, 0x48, 0x30 and 0x38 change nothing.
- R12: Bits 31 to 19 of every high word read zero, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 51 | Interrupt source pins, sampled every clock |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Normal interrupt line, registered |
| fiq_out | output | 1 | Fast interrupt line, registered |

## Verification
A pin change is sampled at the next rising edge. The raw bit and every status word are therefore readable one cycle after the stimulus, and irq_out and fiq_out respond one cycle after that. A register write takes effect at the edge that samples it, so a read placed on the following falling edge sees the new value. The output lines again trail the write by one further cycle. The bench's driver issues each stimulus or read on a falling edge and queues the expected value. The monitor compares the queue midway through the low phase, so every check lands on the cycle the latency count gives. The same-cycle edge and clear case is driven on a single edge so that the ordering rule is exercised.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int SRC_N  = 51;
  localparam int WORD_W = 32;

  typedef logic [63:0] wide_t;

  // Fixed trigger configuration and writable polarity bits
  localparam wide_t MODE_RST  = 64'h0000_1F07_FFF8_FFFF;
  localparam wide_t BOTH_RST  = 64'h0000_00F8_0007_0000;
  localparam wide_t POL_RST   = 64'h0000_5F07_FFF8_FFFF;
  localparam wide_t POL_WMASK = 64'h0007_8000_0000_0000;

  typedef enum logic [3:0] {
    RS_NONE, RS_IRQ_ST, RS_FIQ_ST, RS_RAW, RS_ROUTE, RS_EN_SET, RS_EN_CLR,
    RS_SW_SET, RS_SW_CLR, RS_MODE, RS_BOTH, RS_POL, RS_EDGE_CLR, RS_EDGE_ST
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [6:0] off);
    case (off)
      7'h00:   return RS_IRQ_ST;
      7'h08:   return RS_FIQ_ST;
      7'h10:   return RS_RAW;
      7'h18:   return RS_ROUTE;
      7'h20:   return RS_EN_SET;
      7'h28:   return RS_EN_CLR;
      7'h30:   return RS_SW_SET;
      7'h38:   return RS_SW_CLR;
      7'h40:   return RS_MODE;
      7'h48:   return RS_BOTH;
      7'h50:   return RS_POL;
      7'h58:   return RS_EDGE_CLR;
      7'h60:   return RS_EDGE_ST;
      default: return RS_NONE;
    endcase
  endfunction

  function automatic logic level_active(input logic pol, input logic pin);
    return pol ? pin : ~pin;
  endfunction

  function automatic logic edge_seen(input logic both, input logic pol,
                                     input logic was, input logic now);
    if (both) return was ^ now;
    return pol ? (now & ~was) : (was & ~now);
  endfunction

  function automatic wide_t place_word(input logic [WORD_W-1:0] d, input logic hi);
    return hi ? (wide_t'(d) << WORD_W) : wide_t'(d);
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input wide_t v, input logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

endpackage

// File: rtl/intc_trigger.sv
module intc_trigger #(
  parameter int N = 51
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] mode_v,
  input  logic [N-1:0] both_v,
  input  logic [N-1:0] pol_v,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] raw_q,
  output logic [N-1:0] edge_hit
);

  logic [N-1:0] prev_q;
  logic [N-1:0] raw_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign edge_hit[i] = ~mode_v[i] &
                         intc_pkg::edge_seen(both_v[i], pol_v[i], prev_q[i], src_in[i]);
    assign raw_d[i] = mode_v[i] ? intc_pkg::level_active(pol_v[i], src_in[i])
                                : ((raw_q[i] & ~clr_mask[i]) | edge_hit[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= src_in;
      raw_q  <= raw_d;
    end
  end

endmodule

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int           N        = 51,
  parameter int           ADDR_W   = 8,
  parameter logic [N-1:0] MODE_V   = '0,
  parameter logic [N-1:0] BOTH_V   = '0,
  parameter logic [N-1:0] POL_INIT = '0,
  parameter logic [N-1:0] POL_WM   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [N-1:0]      raw_q,
  output logic [31:0]       bus_rdata,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      route_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      clr_mask
);
  import intc_pkg::*;

  localparam int UP_W = ADDR_W - 7;

  logic           hit, hi;
  reg_sel_e       rsel;
  logic [N-1:0]   wvec, hmask, rvec;

  assign hit   = (bus_addr[ADDR_W-1:7] == UP_W'(1)) && (bus_addr[1:0] == 2'b00);
  assign hi    = bus_addr[2];
  assign rsel  = hit ? decode_off({bus_addr[6:3], 3'b000}) : RS_NONE;
  assign wvec  = N'(place_word(bus_wdata, hi));
  assign hmask = N'(place_word('1, hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      pol_q   <= POL_INIT;
    end else if (bus_wr) begin
      case (rsel)
        RS_ROUTE:  route_q <= (route_q & ~hmask) | wvec;
        RS_EN_SET: en_q    <= en_q | wvec;
        RS_EN_CLR: en_q    <= en_q & ~wvec;
        RS_POL:    if (hi) pol_q <= (pol_q & ~POL_WM) | (wvec & POL_WM);
        default:   ;
      endcase
    end
  end

  assign clr_mask = (bus_wr && rsel == RS_EDGE_CLR) ? (wvec & ~MODE_V) : '0;

  always_comb begin
    case (rsel)
      RS_IRQ_ST:  rvec = raw_q & en_q & ~route_q;
      RS_FIQ_ST:  rvec = raw_q & en_q & route_q;
      RS_RAW:     rvec = raw_q;
      RS_ROUTE:   rvec = route_q;
      RS_EN_SET:  rvec = en_q;
      RS_MODE:    rvec = MODE_V;
      RS_BOTH:    rvec = BOTH_V;
      RS_POL:     rvec = pol_q;
      RS_EDGE_ST: rvec = raw_q & ~MODE_V;
      default:    rvec = '0;
    endcase
  end

  assign bus_rdata = pick_word(wide_t'(rvec), hi);

endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc #(
  parameter int N_SRC  = intc_pkg::SRC_N,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic              fiq_out
);

  localparam logic [N_SRC-1:0] MODE_V   = N_SRC'(intc_pkg::MODE_RST);
  localparam logic [N_SRC-1:0] BOTH_V   = N_SRC'(intc_pkg::BOTH_RST);
  localparam logic [N_SRC-1:0] POL_INIT = N_SRC'(intc_pkg::POL_RST);
  localparam logic [N_SRC-1:0] POL_WM   = N_SRC'(intc_pkg::POL_WMASK);

  logic [N_SRC-1:0] raw_q, edge_hit, en_q, route_q, pol_q, clr_mask;
  logic             irq_pend, fiq_pend;

  intc_trigger #(.N(N_SRC)) u_trig (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .mode_v(MODE_V), .both_v(BOTH_V), .pol_v(pol_q),
    .clr_mask(clr_mask), .raw_q(raw_q), .edge_hit(edge_hit)
  );

  intc_regs #(
    .N(N_SRC), .ADDR_W(ADDR_W), .MODE_V(MODE_V), .BOTH_V(BOTH_V),
    .POL_INIT(POL_INIT), .POL_WM(POL_WM)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .raw_q(raw_q), .bus_rdata(bus_rdata),
    .en_q(en_q), .route_q(route_q), .pol_q(pol_q), .clr_mask(clr_mask)
  );

  assign irq_pend = |(raw_q & en_q & ~route_q);
  assign fiq_pend = |(raw_q & en_q & route_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
      fiq_out <= 1'b0;
    end else begin
      irq_out <= irq_pend;
      fiq_out <= fiq_pend;
    end
  end

endmodule

// File: rtl/dual_line_intc_chk.sv
module dual_line_intc_chk #(
  parameter int N = 51
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [N-1:0] src_in,
  input logic [N-1:0] raw_q,
  input logic [N-1:0] edge_hit,
  input logic [N-1:0] clr_mask,
  input logic [N-1:0] en_q,
  input logic [N-1:0] route_q,
  input logic [N-1:0] pol_q,
  input logic [N-1:0] mode_v,
  input logic         irq_pend,
  input logic         fiq_pend,
  input logic         irq_out,
  input logic         fiq_out
);

  a_r2_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q ^ $past(src_in)) & mode_v & pol_q & $past(pol_q)) == '0);

  a_r3_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_q) & ~raw_q & ~mode_v & ~$past(clr_mask)) == '0);

  a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((raw_q & $past(edge_hit)) == $past(edge_hit)));

  a_r7_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (en_q == $past(en_q)));

  a_r8_route_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (route_q == $past(route_q)));

  a_r9_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |=> irq_out);

  a_r9_fiq_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_pend |=> !fiq_out);

endmodule

bind dual_line_intc dual_line_intc_chk #(.N(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .src_in(src_in),
  .raw_q(raw_q), .edge_hit(edge_hit), .clr_mask(clr_mask), .en_q(en_q),
  .route_q(route_q), .pol_q(pol_q), .mode_v(MODE_V), .irq_pend(irq_pend),
  .fiq_pend(fiq_pend), .irq_out(irq_out), .fiq_out(fiq_out)
);

// File: tb/sim_dual_line_intc.sv
module sim_dual_line_intc;
  localparam int N  = 51;
  localparam int AW = 8;
  localparam int K_RD = 0, K_IRQ = 1, K_FIQ = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, fiq;

  always #10 clk = ~clk;

  dual_line_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_wr(wr_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_out(irq), .fiq_out(fiq)
  );

  typedef struct {int kind; logic [31:0] exp; string tag;} item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Monitor: compares queued expectations mid-low-phase
  always begin
    @(negedge clk);
    #5;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = (it.kind == K_RD) ? rdata : (it.kind == K_IRQ) ? {31'b0, irq} : {31'b0, fiq};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic int ra(input int off, input bit hi);
    return 'h80 + off + (hi ? 4 : 0);
  endfunction

  task automatic rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = AW'(a);
    q.push_back('{K_RD, e, t});
  endtask

  task automatic out_chk(input int k, input logic v, input string t);
    @(negedge clk);
    q.push_back('{k, {31'b0, v}, t});
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic drv(input int idx, input logic v);
    @(negedge clk);
    src[idx] = v;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(ra('h40,0), 32'hFFF8FFFF, "R1 mode lo");
    rd(ra('h40,1), 32'h00001F07, "R1 mode hi");
    rd(ra('h48,0), 32'h00070000, "R1 both lo");
    rd(ra('h48,1), 32'h000000F8, "R1 both hi");
    rd(ra('h50,0), 32'hFFF8FFFF, "R1 pol lo");
    rd(ra('h50,1), 32'h00005F07, "R1 pol hi");
    rd(ra('h10,0), 32'h0, "R1 raw lo");
    rd(ra('h20,0), 32'h0, "R1 enable lo");
    rd(ra('h18,1), 32'h0, "R1 route hi");
    out_chk(K_IRQ, 1'b0, "R1 irq low");
    out_chk(K_FIQ, 1'b0, "R1 fiq low");
    // R7 enable set/clear
    wr(ra('h20,0), 32'h5);
    rd(ra('h20,0), 32'h5, "R7 enable set lo");
    wr(ra('h20,1), 32'h4000);
    rd(ra('h20,1), 32'h4000, "R7 enable set hi");
    wr(ra('h28,0), 32'h4);
    rd(ra('h20,0), 32'h1, "R7 enable clear lo");
    // R2 / R9 level source 0 on the normal line
    drv(0, 1'b1);
    out_chk(K_IRQ, 1'b0, "R9 irq not yet");
    out_chk(K_IRQ, 1'b1, "R9 irq raised");
    rd(ra('h10,0), 32'h1, "R2 level raw high");
    rd(ra('h00,0), 32'h1, "R8 irq status");
    rd(ra('h08,0), 32'h0, "R8 fiq status");
    drv(0, 1'b0);
    rd(ra('h10,0), 32'h0, "R2 level raw follows low");
    out_chk(K_IRQ, 1'b0, "R9 irq dropped");
    // R8 / R9 fast line and half-word route writes
    wr(ra('h18,0), 32'h1);
    drv(0, 1'b1);
    out_chk(K_FIQ, 1'b0, "R9 fiq not yet");
    out_chk(K_FIQ, 1'b1, "R9 fiq raised");
    out_chk(K_IRQ, 1'b0, "R9 irq stays low when routed fast");
    rd(ra('h08,0), 32'h1, "R8 fiq status set");
    rd(ra('h00,0), 32'h0, "R8 irq status clear");
    drv(0, 1'b0);
    wr(ra('h18,1), 32'h4000);
    rd(ra('h18,0), 32'h1, "R8 route lo kept");
    rd(ra('h18,1), 32'h4000, "R8 route hi written");
    wr(ra('h18,0), 32'h0);
    rd(ra('h18,1), 32'h4000, "R8 route hi kept");
    rd(ra('h18,0), 32'h0, "R8 route lo written");
    wr(ra('h18,1), 32'hFFFFFFFF);
    rd(ra('h18,1), 32'h0007FFFF, "R12 high word upper bits zero");
    wr(ra('h18,1), 32'h0);
    // R3 rising edge source 46
    drv(46, 1'b1);
    rd(ra('h10,1), 32'h4000, "R3 rising sets raw");
    out_chk(K_IRQ, 1'b1, "R9 edge drives irq");
    drv(46, 1'b0);
    rd(ra('h10,1), 32'h4000, "R3 raw sticky");
    rd(ra('h60,1), 32'h4000, "R8 edge status");
    wr(ra('h58,1), 32'h4000);
    rd(ra('h10,1), 32'h0, "R3 cleared");
    // R6 clear has no effect on level source
    drv(0, 1'b1);
    wr(ra('h58,0), 32'h1);
    rd(ra('h10,0), 32'h1, "R6 level not cleared");
    drv(0, 1'b0);
    // R4 falling edge source 45
    drv(45, 1'b1);
    rd(ra('h10,1), 32'h0, "R4 rising ignored");
    drv(45, 1'b0);
    rd(ra('h10,1), 32'h2000, "R4 falling sets raw");
    wr(ra('h58,1), 32'h2000);
    rd(ra('h10,1), 32'h0, "R4 cleared");
    // R5 both edges source 16
    drv(16, 1'b1);
    rd(ra('h10,0), 32'h10000, "R5 rise sets raw");
    wr(ra('h58,0), 32'h10000);
    rd(ra('h10,0), 32'h0, "R5 cleared");
    drv(16, 1'b0);
    rd(ra('h10,0), 32'h10000, "R5 fall sets raw");
    wr(ra('h58,0), 32'h10000);
    rd(ra('h10,0), 32'h0, "R5 cleared again");
    // R6 edge and clear in the same cycle
    @(negedge clk);
    src[46] = 1'b1;
    wr_en = 1'b1; addr = AW'(ra('h58,1)); wdata = 32'h4000;
    @(posedge clk);
    #1 wr_en = 1'b0;
    rd(ra('h10,1), 32'h4000, "R6 edge wins over clear");
    drv(46, 1'b0);
    wr(ra('h58,1), 32'h4000);
    rd(ra('h10,1), 32'h0, "R6 cleared");
    // R10 polarity writes
    wr(ra('h50,1), 32'hFFFFFFFF);
    rd(ra('h50,1), 32'h0007DF07, "R10 only bits 15-18 change");
    wr(ra('h50,0), 32'h0);
    rd(ra('h50,0), 32'hFFF8FFFF, "R10 low write ignored");
    drv(47, 1'b1);
    rd(ra('h10,1), 32'h8000, "R10 source 47 now rising");
    wr(ra('h58,1), 32'h8000);
    wr(ra('h50,1), 32'h0);
    rd(ra('h50,1), 32'h00005F07, "R10 polarity restored");
    drv(47, 1'b0);
    rd(ra('h10,1), 32'h8000, "R10 source 47 falling again");
    wr(ra('h58,1), 32'h8000);
    rd(ra('h10,1), 32'h0, "R10 cleared");
    // R11 inert space and registers
    rd('h10, 32'h0, "R11 legacy read zero");
    wr('h20, 32'hFFFFFFFF);
    rd(ra('h20,0), 32'h1, "R11 legacy write ignored");
    rd(ra('h28,0), 32'h0, "R11 enable clear reads zero");
    rd(ra('h58,0), 32'h0, "R11 edge clear reads zero");
    wr(ra('h40,0), 32'h0);
    rd(ra('h40,0), 32'hFFF8FFFF, "R11 mode write ignored");
    wr(ra('h48,1), 32'h0);
    rd(ra('h48,1), 32'h000000F8, "R11 both-edge write ignored");
    drv(0, 1'b1);
    wr(ra('h10,0), 32'h0);
    rd(ra('h10,0), 32'h1, "R11 raw write ignored");
    drv(0, 1'b0);
    rd(ra('h68,0), 32'h0, "R11 unmapped reads zero");
    wr(ra('h30,0), 32'hFFFFFFFF);
    rd(ra('h30,0), 32'h0, "R11 software set reads zero");
    rd(ra('h10,0), 32'h0, "R11 software set no effect");
    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule